// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers the single-cycle event pulses raised by an I2C transfer engine and holds each one in a sticky status bit. Software reads the collected status over a simple register bus and clears bits by writing ones to them. A per-source mask decides which held events may raise the interrupt request line. The mask has no direct write path. Software changes it only through two write-only strobe registers. One of them unmasks the bits written as 1, and the other masks them.

The register bus has no handshake. A read returns its data combinationally in the same cycle as `rd_en`. A write takes effect at the next rising clock edge. The interrupt request is a registered OR of every status bit whose mask bit is clear. It therefore follows the status and mask state one clock later.

Top module: `irq_status_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all status bits go to 0 and all implemented mask bits go to 1. After reset the status register therefore reads 0x000, the mask register reads 0x2FF and `irq` is 0.
- R2: An event pulse on `evt[i]` sets status bit i at that clock edge, and the bit then stays set. The sources map to bits as follows: 0 done, 1 data, 2 no-acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: Bit 8 is reserved. A pulse on `evt[8]` is ignored, and bit 8 reads 0 in both the status register and the mask register whatever is written.
- R4: A write to the status register at byte offset 0x10 clears each status bit whose `wdata` bit is 1 and leaves the others unchanged. Writing 0xFF clears bits 0 to 7 and leaves bit 9 as it was.
- R5: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R6: A write to the enable register at offset 0x24 clears each mask bit whose `wdata` bit is 1, which unmasks that source. Bits written as 0 leave the mask unchanged.
- R7: A write to the disable register at offset 0x28 sets each implemented mask bit whose `wdata` bit is 1, which masks that source. Bits written as 0 leave the mask unchanged.
- R8: The mask register at offset 0x20 can be read but not written. A write to it has no effect. The enable and disable registers read as 0. Any other offset reads 0, and a write to it changes nothing.
- R9: `irq` is 1 in a cycle exactly when, in the previous cycle, some status bit was set while its mask bit was clear.
- R10: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt | input | 10 | Event pulses from the transfer engine, one per status bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims first at an event pulse that coincides with a clearing write on the same bit. A design that lets the clear win would lose that event, and the bit would read 0 afterwards. It then drives the reserved bit 8 through events, clears, enables and disables. A design that stored bit 8 would report 0x100 in status or mask. It writes 0xFF with bit 9 set and checks that bit 9 survives, because a decoder that clears too widely would drop the arbitration-lost flag. Finally it times `irq` one cycle after each unmasking and masking. A combinational or doubly registered request would appear a cycle early or a cycle late.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants for the interrupt status and mask unit: the register
// offsets on the bus, the number of sources, and the implemented-bit vector.
// Assumes byte offsets that fit in ADDR_W bits.
package irq_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NUM_SRC  = 10;
    localparam int RSVD_BIT = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_DISABLE = 8'h28;

    // Build the implemented-bit vector: every bit except the reserved one.
    function automatic logic [NUM_SRC-1:0] impl_vec();
        logic [NUM_SRC-1:0] v;
        for (int i = 0; i < NUM_SRC; i++) begin
            v[i] = (i != RSVD_BIT);
        end
        return v;
    endfunction

    localparam logic [NUM_SRC-1:0] IMPL_BITS = impl_vec();

endpackage

// File: rtl/irq_status_bank.sv
// Module irq_status_bank
// Holds one sticky status flag per implemented source. An event pulse sets
// its flag. A clearing write drops each flag written as 1. When both reach a
// flag in the same cycle, the set wins. Unimplemented positions are tied to 0.
// Assumes event pulses are synchronous to clk.
module irq_status_bank #(
    parameter int              N    = 10,
    parameter logic [N-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);

    logic [N-1:0] unused_bits;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // Sticky flag: the set has priority over the clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status[i] <= 1'b0;
                end else if (evt[i]) begin
                    status[i] <= 1'b1;
                end else if (clr_we && clr_bits[i]) begin
                    status[i] <= 1'b0;
                end
            end
            assign unused_bits[i] = 1'b0;
        end else begin : g_rsvd
            assign status[i]      = 1'b0;
            assign unused_bits[i] = evt[i] ^ clr_bits[i];
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Module irq_mask_bank
// Holds one mask flag per implemented source. A 1 in the flag blocks that
// source from the request line. The enable strobe clears the flags written
// as 1 and the disable strobe sets them. There is no direct write path.
// Assumes the two strobes never arrive together, since they come from
// distinct bus offsets.
module irq_mask_bank #(
    parameter int              N    = 10,
    parameter logic [N-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         dis_we,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);

    logic [N-1:0] unused_bits;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // Mask flag: comes out of reset masked and changes only on a strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask[i] <= 1'b1;
                end else if (en_we && bits[i]) begin
                    mask[i] <= 1'b0;
                end else if (dis_we && bits[i]) begin
                    mask[i] <= 1'b1;
                end
            end
            assign unused_bits[i] = 1'b0;
        end else begin : g_rsvd
            assign mask[i]        = 1'b0;
            assign unused_bits[i] = bits[i];
        end
    end

endmodule

// File: rtl/irq_bus_decode.sv
// Module irq_bus_decode
// Decodes the register bus. It produces the write strobes for the status
// clear and the mask enable and disable, and it steers the read data.
// Write-only and unmapped offsets read 0, and rdata is 0 without rd_en.
// Assumes reads are combinational and writes land on the next clock edge.
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      status,
    input  logic [N-1:0]      mask,
    output logic              stat_we,
    output logic              en_we,
    output logic              dis_we,
    output logic [DATA_W-1:0] rdata
);

    // Write strobes, one per writable offset.
    always_comb begin
        stat_we = wr_en && (addr == OFS_STATUS);
        en_we   = wr_en && (addr == OFS_ENABLE);
        dis_we  = wr_en && (addr == OFS_DISABLE);
    end

    // Read mux: only status and mask return data.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_STATUS: rdata[N-1:0] = status;
                OFS_MASK:   rdata[N-1:0] = mask;
                default:    rdata        = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_req_gen.sv
// Module irq_req_gen
// Registers the interrupt request: the OR over all sources that are held
// in status and not masked. It assumes status and mask come straight from
// flops, so that the request lags them by exactly one cycle.
module irq_req_gen #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] mask,
    output logic         irq
);

    logic pending;

    // Combine the pending sources.
    always_comb begin
        pending = |(status & ~mask);
    end

    // Register the request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= pending;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
// Module irq_status_unit
// Top of the interrupt aggregator. It latches event pulses into sticky
// status, keeps a set/clear mask, decodes the register bus and drives one
// registered request line. It assumes a single clock and a synchronous
// active-low reset.
module irq_status_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               stat_we;
    logic               en_we;
    logic               dis_we;
    logic [NUM_SRC-1:0] wbits;
    logic               unused_hi;

    assign wbits     = wdata[NUM_SRC-1:0];
    assign unused_hi = ^wdata[DATA_W-1:NUM_SRC];

    irq_bus_decode #(.N(NUM_SRC)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .status  (status_q),
        .mask    (mask_q),
        .stat_we (stat_we),
        .en_we   (en_we),
        .dis_we  (dis_we),
        .rdata   (rdata)
    );

    irq_status_bank #(.N(NUM_SRC), .IMPL(IMPL_BITS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_we   (stat_we),
        .clr_bits (wbits),
        .status   (status_q)
    );

    irq_mask_bank #(.N(NUM_SRC), .IMPL(IMPL_BITS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (en_we),
        .dis_we (dis_we),
        .bits   (wbits),
        .mask   (mask_q)
    );

    irq_req_gen #(.N(NUM_SRC)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .mask   (mask_q),
        .irq    (irq)
    );

endmodule

// File: rtl/irq_status_chk.sv
// Module irq_status_chk
// Checker bound to irq_status_unit. It relates the bus writes and event
// pulses to the next-cycle status, mask and request values.
module irq_status_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] mask,
    input logic               irq
);

    // R2: an implemented event sets its bit by the next cycle
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt & IMPL_BITS) |=> ((status & $past(evt & IMPL_BITS)) == $past(evt & IMPL_BITS)));

    // R3: the reserved bit never holds a value
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[RSVD_BIT] == 1'b0) && (mask[RSVD_BIT] == 1'b0));

    // R4 and R5: a clear removes the written bits unless an event hits them
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STATUS) |=> ((status & $past(wdata[NUM_SRC-1:0] & ~evt)) == '0));

    // R5: an event wins over a simultaneous clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STATUS && |(evt & wdata[NUM_SRC-1:0] & IMPL_BITS))
        |=> ((status & $past(evt & wdata[NUM_SRC-1:0] & IMPL_BITS)) != '0));

    // R6: the enable strobe unmasks the written bits
    a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ENABLE) |=> ((mask & $past(wdata[NUM_SRC-1:0])) == '0));

    // R7: the disable strobe masks the written implemented bits
    a_r7_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DISABLE)
        |=> ((mask & $past(wdata[NUM_SRC-1:0] & IMPL_BITS)) == $past(wdata[NUM_SRC-1:0] & IMPL_BITS)));

    // R8: the mask holds when neither strobe is written
    a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == OFS_ENABLE || addr == OFS_DISABLE)) |=> $stable(mask));

    // R9: the request follows pending sources by one cycle
    a_r9_irq_timing: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & ~mask))));

endmodule

bind irq_status_unit irq_status_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .status (status_q),
    .mask   (mask_q),
    .irq    (irq)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 10;
    localparam logic [N-1:0] IMPL = 10'h2FF;
    localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h20, A_EN = 8'h24, A_DIS = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_st;
    logic [N-1:0] m_mk;
    logic         m_irq;

    irq_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference read value from the requirements.
    function automatic logic [31:0] exp_rd(input logic rd, input logic [7:0] a,
                                           input logic [N-1:0] st, input logic [N-1:0] mk);
        logic [31:0] r = '0;
        if (rd && a == A_ST) r[N-1:0] = st;
        else if (rd && a == A_MK) r[N-1:0] = mk;
        return r;
    endfunction

    function automatic logic [N-1:0] next_st(input logic [N-1:0] st, input logic [N-1:0] e,
                                             input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [N-1:0] s = st;
        if (w && a == A_ST) s = s & ~d[N-1:0];
        return (s | e) & IMPL;
    endfunction

    function automatic logic [N-1:0] next_mk(input logic [N-1:0] mk, input logic w,
                                             input logic [7:0] a, input logic [31:0] d);
        logic [N-1:0] m = mk;
        if (w && a == A_EN)  m = m & ~d[N-1:0];
        if (w && a == A_DIS) m = m | d[N-1:0];
        return m & IMPL;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, check, then advance the model.
    task automatic step(input logic [N-1:0] e, input logic w, input logic r,
                        input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        evt = e; wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        check("R10/R8 rdata", rdata, exp_rd(r, a, m_st, m_mk));
        check("R9 irq", {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        m_irq = |(m_st & ~m_mk);
        m_st  = next_st(m_st, e, w, a, d);
        m_mk  = next_mk(m_mk, w, a, d);
    endtask

    task automatic idle();
        step('0, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    // Read a register and compare with a literal value.
    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        evt = '0; wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0;
        #1;
        check(tag, rdata, v);
        @(posedge clk);
        m_irq = |(m_st & ~m_mk);
    endtask

    task automatic expect_irq(input string tag, input logic v);
        @(negedge clk);
        #1;
        check(tag, {31'b0, irq}, {31'b0, v});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] addrs [5];
        void'($urandom(32'h1A2B3C));
        addrs[0] = A_ST; addrs[1] = A_MK; addrs[2] = A_EN; addrs[3] = A_DIS; addrs[4] = 8'h14;
        m_st = '0; m_mk = IMPL; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        expect_reg("R1 status reset", A_ST, 32'h0);
        expect_reg("R1 mask reset", A_MK, 32'h2FF);
        expect_irq("R1 irq reset", 1'b0);

        // R2: each source sets its bit and it stays
        for (int i = 0; i < N; i++) begin
            step(N'(1) << i, 1'b0, 1'b0, 8'h0, 32'h0);
        end
        idle();
        expect_reg("R2 all sticky, R3 bit8 ignored", A_ST, 32'h2FF);

        // R4: 0xFF clears low byte, bit 9 survives
        step('0, 1'b1, 1'b0, A_ST, 32'hFF);
        expect_reg("R4 0xFF keeps bit9", A_ST, 32'h200);
        step('0, 1'b1, 1'b0, A_ST, 32'h0);
        expect_reg("R4 zero write no effect", A_ST, 32'h200);

        // R5: event and clear collide
        step(10'h004, 1'b1, 1'b0, A_ST, 32'h204);
        expect_reg("R5 set wins", A_ST, 32'h004);

        // R3: reserved bit through every path
        step('0, 1'b1, 1'b0, A_EN, 32'h100);
        step('0, 1'b1, 1'b0, A_DIS, 32'h100);
        expect_reg("R3 mask bit8 zero", A_MK, 32'h2FF);

        // R8: writes to mask/unmapped ignored; write-only regs read 0
        step('0, 1'b1, 1'b0, A_MK, 32'h0);
        step('0, 1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF);
        expect_reg("R8 mask not writable", A_MK, 32'h2FF);
        expect_reg("R8 unmapped write ignored", A_ST, 32'h004);
        expect_reg("R8 enable reads 0", A_EN, 32'h0);
        expect_reg("R8 disable reads 0", A_DIS, 32'h0);

        // R6 and R9: unmask bit 2, irq rises one cycle after the mask changes
        expect_irq("R9 masked no irq", 1'b0);
        step('0, 1'b1, 1'b0, A_EN, 32'h004);
        expect_irq("R9 irq lags mask", 1'b0);
        @(posedge clk);
        expect_irq("R9 irq asserted", 1'b1);
        expect_reg("R6 enable clears mask bit", A_MK, 32'h2FB);

        // R7: mask again, irq drops a cycle later
        step('0, 1'b1, 1'b0, A_DIS, 32'h004);
        expect_irq("R7 irq lags disable", 1'b1);
        @(posedge clk);
        expect_irq("R7 irq dropped", 1'b0);
        expect_reg("R7 disable sets mask bit", A_MK, 32'h2FF);
        m_irq = 1'b0;

        // R10: rdata is zero without rd_en
        step('0, 1'b0, 1'b0, A_MK, 32'h0);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] e;
            e = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
            step(e, ($urandom % 3) == 0, ($urandom % 2) == 0,
                 addrs[$urandom % 5], $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule